// File: doc/BRIEF.md
# Retriggerable gated one-shot pulse generator

This block produces a single output pulse, counted in clock cycles, each time a gated trigger condition becomes true. Two groups of asynchronous trigger pins feed it. The low-active group is active when any of its pins is low. The high-active group is active only when all of its pins are high. The condition is true when both groups are active and the active-low clear pin is released. Each pin passes through a two-flop synchronizer and then a level qualifier. The qualifier accepts a new level only after that level has held for a programmable number of cycles.

A rising edge of the condition loads the width counter from `width_cfg`, and the pulse output stays high while the counter is non-zero. A later accepted edge reloads the counter, which stretches the pulse, so regular retriggering can keep the output high indefinitely. A short lockout window follows every accepted edge, and edges that arrive inside it are ignored. Driving the clear pin low forces the outputs at once. Once the synchronized clear is low, it also empties the counter, so the pulse ends early and does not come back.

Top module: `retrig_oneshot`

## Requirements
- R1: A trigger is the condition (any low-active pin at 0) AND (every high-active pin at 1) AND (clear at 1), evaluated on qualified levels and going from false to true. A condition that stays true, or a partial group (for example high-active pins 2'b01), produces no pulse.
- R2: Clear going high while the low-active group is active and every high-active pin is high counts as a trigger.
- R3: While `clr_n` is 0, `pulse_q` is 0 and `pulse_qn` is 1 within the same cycle, combinationally from the pin.
- R4: A synchronized low clear empties the width counter, so a truncated pulse does not resume after clear is released.
- R5: An accepted trigger gives a pulse exactly `width_cfg` cycles long. A `width_cfg` of 0 gives no pulse.
- R6: An accepted trigger during a pulse reloads the full width, so the pulse ends `width_cfg` cycles after the last accepted trigger.
- R7: For `lock_cfg` cycles after an accepted trigger, further rising edges of the condition are ignored. A `lock_cfg` of 0 disables the window.
- R8: A synchronized pin level is accepted only after it has differed from the qualified level for `qual_cfg`+1 consecutive cycles. Shorter excursions are dropped.
- R9: From a pin change that completes a trigger, `pulse_q` is first seen high at the 4+`qual_cfg`-th falling clock edge.
- R10: `pulse_qn` is always the complement of `pulse_q`, and both are 0/1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_lo_n | input | N_LOW | Low-active trigger group |
| trig_hi | input | N_HIGH | High-active trigger group |
| clr_n | input | 1 | Active-low overriding clear |
| width_cfg | input | CNT_W | Pulse width in cycles |
| qual_cfg | input | QUAL_W | Extra qualifying cycles per pin |
| lock_cfg | input | LOCK_W | Lockout length in cycles |
| pulse_q | output | 1 | Pulse output |
| pulse_qn | output | 1 | Complement of pulse output |

## Verification
The width counter and lockout counter are visible only through `pulse_q`. A wrong counter value shows up as a pulse that ends early or late, and this is visible within one width after the fault. A lockout counter that clears too early or too late shows up as a pulse stretched by a retrigger that should have been ignored, or not stretched by one that should have been accepted. A wrong qualified level or a stale edge register changes when the pulse starts, so a reference model is compared with the outputs on every cycle, which catches a one-cycle shift at the very next falling edge.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // True when any of the first n bits is 0.
  function automatic logic any_low(input logic [31:0] v, input int n);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 32; i++)
      if (i < n && !v[i]) r = 1'b1;
    return r;
  endfunction

  // True when all of the first n bits are 1.
  function automatic logic all_high(input logic [31:0] v, input int n);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 32; i++)
      if (i < n && !v[i]) r = 1'b0;
    return r;
  endfunction

  // Saturating decrement toward zero.
  function automatic logic [31:0] step_down(input logic [31:0] v);
    return (v == 32'd0) ? 32'd0 : v - 32'd1;
  endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST;
      stage2 <= RST;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/os_qualify.sv
module os_qualify #(
  parameter int           W   = 1,
  parameter int           CW  = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  d,
  input  logic [CW-1:0] limit,
  output logic [W-1:0]  q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [CW-1:0] run;
    logic          lvl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run <= '0;
        lvl <= RST[g];
      end else if (d[g] == lvl) begin
        run <= '0;
      end else if (run >= limit) begin
        lvl <= d[g];
        run <= '0;
      end else begin
        run <= run + CW'(1);
      end
    end

    assign q[g] = lvl;
  end
endmodule

// File: rtl/os_timer.sv
module os_timer
  import oneshot_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              fire_req,
  input  logic [CNT_W-1:0]  width,
  input  logic [LOCK_W-1:0] lock_len,
  output logic              fire_ok,
  output logic [CNT_W-1:0]  count_q,
  output logic [LOCK_W-1:0] lock_q,
  output logic              busy
);
  logic [31:0] cnt_dec;
  logic [31:0] lock_dec;

  assign fire_ok  = fire_req && (lock_q == '0);
  assign cnt_dec  = step_down(32'(count_q));
  assign lock_dec = step_down(32'(lock_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      lock_q  <= '0;
    end else if (kill) begin
      count_q <= '0;
      lock_q  <= '0;
    end else if (fire_ok) begin
      count_q <= width;
      lock_q  <= lock_len;
    end else begin
      count_q <= cnt_dec[CNT_W-1:0];
      lock_q  <= lock_dec[LOCK_W-1:0];
    end
  end

  assign busy = (count_q != '0);
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int N_LOW  = 2,
  parameter int N_HIGH = 2,
  parameter int CNT_W  = 16,
  parameter int QUAL_W = 4,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LOW-1:0]  trig_lo_n,
  input  logic [N_HIGH-1:0] trig_hi,
  input  logic              clr_n,
  input  logic [CNT_W-1:0]  width_cfg,
  input  logic [QUAL_W-1:0] qual_cfg,
  input  logic [LOCK_W-1:0] lock_cfg,
  output logic              pulse_q,
  output logic              pulse_qn
);
  localparam int NIN = N_LOW + N_HIGH + 1;
  localparam int CLR_IDX = NIN - 1;
  localparam logic [NIN-1:0] RST_VEC = {1'b1, {N_HIGH{1'b0}}, {N_LOW{1'b1}}};

  logic [NIN-1:0]    raw_vec;
  logic [NIN-1:0]    sync_vec;
  logic [NIN-1:0]    qual_vec;
  logic              clr_sync;
  logic              cond_now;
  logic              cond_d;
  logic              cond_rise;
  logic              fire_ok;
  logic [CNT_W-1:0]  count_q;
  logic [LOCK_W-1:0] lock_q;
  logic              busy;

  assign raw_vec = {clr_n, trig_hi, trig_lo_n};

  os_sync #(.W(NIN), .RST(RST_VEC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(sync_vec)
  );

  os_qualify #(.W(NIN), .CW(QUAL_W), .RST(RST_VEC)) u_qual (
    .clk(clk), .rst_n(rst_n), .d(sync_vec), .limit(qual_cfg), .q(qual_vec)
  );

  assign clr_sync = sync_vec[CLR_IDX];

  assign cond_now = any_low(32'(qual_vec[N_LOW-1:0]), N_LOW)
                  && all_high(32'(qual_vec[N_LOW+N_HIGH-1:N_LOW]), N_HIGH)
                  && qual_vec[CLR_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_d <= 1'b0;
    else        cond_d <= cond_now;
  end

  assign cond_rise = cond_now && !cond_d;

  os_timer #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .kill(!clr_sync), .fire_req(cond_rise),
    .width(width_cfg), .lock_len(lock_cfg), .fire_ok(fire_ok),
    .count_q(count_q), .lock_q(lock_q), .busy(busy)
  );

  assign pulse_q  = busy && clr_n;
  assign pulse_qn = !pulse_q;
endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
  parameter int CNT_W  = 16,
  parameter int LOCK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              clr_s,
  input logic              pulse_q,
  input logic              pulse_qn,
  input logic              accept,
  input logic [CNT_W-1:0]  count,
  input logic [LOCK_W-1:0] lock_left,
  input logic [CNT_W-1:0]  width_cfg,
  input logic [LOCK_W-1:0] lock_cfg
);
  AST_CLEAR_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (!pulse_q && pulse_qn)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> (count == '0 && lock_left == '0)); // R4
  AST_RELOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clr_s) |=> count == $past(width_cfg)); // R6
  AST_LOCK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clr_s) |=> lock_left == $past(lock_cfg)); // R7
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !accept && clr_s) |=> count == $past(count) - CNT_W'(1)); // R5
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !pulse_q); // R5
  AST_NO_REPEAT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept); // R1
endmodule

bind retrig_oneshot oneshot_chk #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .clr_s(clr_sync),
  .pulse_q(pulse_q), .pulse_qn(pulse_qn), .accept(fire_ok),
  .count(count_q), .lock_left(lock_q), .width_cfg(width_cfg), .lock_cfg(lock_cfg)
);

// File: tb/test_retrig_oneshot.sv
module test_retrig_oneshot;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lo_n = 2'b11;
  logic [1:0]  hi = 2'b00;
  logic        clr_in = 1'b1;
  logic [15:0] width = 16'd10;
  logic [3:0]  qual = 4'd0;
  logic [3:0]  lockc = 4'd0;
  logic        pulse_q, pulse_qn;

  int vectors = 0;
  int fails = 0;
  int hi_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retrig_oneshot i_retrig_oneshot (
    .clk(clk), .rst_n(rst_n), .trig_lo_n(lo_n), .trig_hi(hi), .clr_n(clr_in),
    .width_cfg(width), .qual_cfg(qual), .lock_cfg(lockc),
    .pulse_q(pulse_q), .pulse_qn(pulse_qn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: pin history -> accepted levels -> edge -> timer.
  int m_s1[5], m_s2[5], m_lvl[5], m_age[5];
  int m_prev, m_cnt, m_lock;

  always @(posedge clk or negedge rst_n) begin
    int pin[5];
    int cond, take;
    pin[0] = lo_n[0]; pin[1] = lo_n[1]; pin[2] = hi[0]; pin[3] = hi[1]; pin[4] = clr_in;
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin
        m_s1[i] = (i == 2 || i == 3) ? 0 : 1;
        m_s2[i] = m_s1[i]; m_lvl[i] = m_s1[i]; m_age[i] = 0;
      end
      m_prev = 0; m_cnt = 0; m_lock = 0;
    end else begin
      cond = ((m_lvl[0] == 0 || m_lvl[1] == 0) && m_lvl[2] == 1 && m_lvl[3] == 1 && m_lvl[4] == 1) ? 1 : 0;
      take = (cond == 1 && m_prev == 0 && m_lock == 0) ? 1 : 0;
      if (m_s2[4] == 0) begin m_cnt = 0; m_lock = 0; end
      else if (take == 1) begin m_cnt = int'(width); m_lock = int'(lockc); end
      else begin
        if (m_cnt > 0) m_cnt--;
        if (m_lock > 0) m_lock--;
      end
      m_prev = cond;
      for (int i = 0; i < 5; i++) begin
        if (m_s2[i] == m_lvl[i]) m_age[i] = 0;
        else if (m_age[i] >= int'(qual)) begin m_lvl[i] = m_s2[i]; m_age[i] = 0; end
        else m_age[i]++;
        m_s2[i] = m_s1[i];
        m_s1[i] = pin[i];
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_q;
      exp_q = (m_cnt != 0 && clr_in) ? 1 : 0;
      chk("R5/R6 model pulse_q", int'(pulse_q), exp_q);
      chk("R10 model pulse_qn", int'(pulse_qn), 1 - exp_q);
      if (pulse_q) hi_cnt++;
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] l, input logic [1:0] h, input logic c);
    @(negedge clk); #1;
    lo_n = l; hi = h; clr_in = c;
  endtask

  task automatic latency(output int lat);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!pulse_q && lat < 60);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int lat;
    settle(3); #1;
    chk("R10 reset pulse_q", int'(pulse_q), 0);
    chk("R10 reset pulse_qn", int'(pulse_qn), 1);
    rst_n = 1'b1;
    settle(6);

    // R1 / R9: high group completes the condition
    drive(2'b10, 2'b00, 1'b1); settle(6);
    hi_cnt = 0;
    drive(2'b10, 2'b11, 1'b1);
    latency(lat);
    chk("R9 latency qual=0", lat, 4);
    settle(30);
    chk("R5 single pulse width 10", hi_cnt, 10);

    // R1: steady condition and partial group never trigger
    hi_cnt = 0; settle(20);
    chk("R1 steady level no pulse", hi_cnt, 0);
    drive(2'b10, 2'b00, 1'b1); settle(6);
    drive(2'b10, 2'b01, 1'b1); settle(20);
    chk("R1 partial high group no pulse", hi_cnt, 0);

    // R1: low group completes the condition
    drive(2'b11, 2'b11, 1'b1); settle(8);
    hi_cnt = 0;
    drive(2'b01, 2'b11, 1'b1); settle(25);
    chk("R1 low-group edge pulse", hi_cnt, 10);

    // R2: clear release with condition met triggers
    drive(2'b11, 2'b00, 1'b0); settle(6);
    drive(2'b10, 2'b11, 1'b0); settle(8);
    hi_cnt = 0;
    drive(2'b10, 2'b11, 1'b1); settle(25);
    chk("R2 clear release trigger", hi_cnt, 10);

    // R5: zero width
    width = 16'd0;
    drive(2'b10, 2'b00, 1'b1); settle(6);
    hi_cnt = 0;
    drive(2'b10, 2'b11, 1'b1); settle(20);
    chk("R5 zero width no pulse", hi_cnt, 0);

    // R6: three edges 16 cycles apart stretch a 20-cycle pulse
    width = 16'd20;
    drive(2'b10, 2'b00, 1'b1); settle(8);
    hi_cnt = 0;
    for (int k = 0; k < 3; k++) begin
      drive(2'b10, 2'b11, 1'b1); settle(7);
      drive(2'b10, 2'b00, 1'b1); settle(7);
    end
    settle(40);
    chk("R6 retrigger stretch", hi_cnt, 52);

    // R3 / R4: clear truncates
    width = 16'd50;
    drive(2'b10, 2'b00, 1'b1); settle(6);
    hi_cnt = 0;
    drive(2'b10, 2'b11, 1'b1); settle(13);
    drive(2'b10, 2'b11, 1'b0); #1;
    chk("R3 clear forces pulse_q low", int'(pulse_q), 0);
    chk("R3 clear forces pulse_qn high", int'(pulse_qn), 1);
    drive(2'b11, 2'b11, 1'b0); settle(6);
    drive(2'b11, 2'b11, 1'b1); settle(60);
    chk("R4 truncated pulse stays ended", hi_cnt, 11);

    // R7: retrigger inside lockout ignored, accepted without lockout
    width = 16'd30; lockc = 4'd6;
    drive(2'b10, 2'b00, 1'b1); settle(6);
    hi_cnt = 0;
    drive(2'b10, 2'b11, 1'b1); settle(1);
    drive(2'b10, 2'b00, 1'b1);
    drive(2'b10, 2'b11, 1'b1); settle(50);
    chk("R7 lockout rejects retrigger", hi_cnt, 30);
    lockc = 4'd0;
    drive(2'b10, 2'b00, 1'b1); settle(6);
    hi_cnt = 0;
    drive(2'b10, 2'b11, 1'b1); settle(1);
    drive(2'b10, 2'b00, 1'b1);
    drive(2'b10, 2'b11, 1'b1); settle(50);
    chk("R7 no lockout accepts retrigger", hi_cnt, 33);

    // R8: short excursion dropped, long one accepted later
    qual = 4'd3;
    drive(2'b10, 2'b00, 1'b1); settle(10);
    hi_cnt = 0;
    drive(2'b10, 2'b11, 1'b1); settle(1);
    drive(2'b10, 2'b00, 1'b1); settle(40);
    chk("R8 short pulse rejected", hi_cnt, 0);
    drive(2'b10, 2'b11, 1'b1);
    latency(lat);
    chk("R8 R9 latency qual=3", lat, 7);
    settle(40);

    summary();
    $finish;
  end
endmodule